// File: doc/BRIEF.md
# Privileged-Mode Shadow Register Controller

This block owns a 32-entry integer register file in which eight registers (8 through 14, and 25) exist twice: one copy for ordinary execution and one for privileged mode. The other registers are shared by both modes. When the core takes a trap from ordinary mode, the shadow copies become the visible ones. A return from exception hides them again, unless the saved restart address carries its privileged marker (bit 0 set). The swap is a change of bank selection, not a copy, so it takes no extra cycles.

The block also works out where the core goes next. On a trap, the new PC is the privileged base address plus an offset chosen by the fault kind, and the following PC is 4 beyond that. The block keeps the exception restart address. On a return it sends the core back to that address and pulses a request to re-check interrupts. A return issued outside privileged mode is reported as an illegal opcode. Arithmetic-trap requests are not taken; they are reported on a separate output. Instruction decode, translation buffers and interrupt arbitration belong to other blocks.

Top module: `priv_shadow_unit`

## Requirements
- R1: Reset (synchronous, `rstN` low) leaves the unit in privileged mode (`privMode`=1) with `pcValid`, `illegalOp`, `recheckIrq`, `unsupFault` and `restartAddr` at 0. Registers 0 and 16 hold the zero-extended `cpuId`; every other register in both banks holds 0.
- R2: Registers 8–14 and 25 each have a separate privileged copy, which is the one read and written while `privMode`=1. All other registers are a single shared copy. `rdData` is a combinational read of register `rdAddr` in the bank of the current mode.
- R3: A register write that lands in the same cycle as a mode change goes to the bank that is active after the change.
- R4: A taken fault (`faultReq`=1, `faultType` other than 5) gives `pcValid`=1 in the next cycle. `newPc` is then `privBase` plus the offset and `newNpc` is `newPc`+4. The offset is 0 for type 0 (no fault), 0x401 for type 1 (machine check), 0x301 for type 2 (alignment), and `faultVec` for types 3, 4, 6 and 7.
- R5: A taken fault stores `curPc` in `restartAddr`. For type 3 (privileged call) it stores `curPc`+4 instead.
- R6: A type-4 fault (interrupt) taken while already in privileged mode leaves `restartAddr` unchanged.
- R7: A taken fault sets `privMode`. The banks switch only when the fault arrives from ordinary mode, so a fault taken in privileged mode leaves the visible registers as they were.
- R8: `retStrobe` in ordinary mode gives `illegalOp`=1 for one cycle. There is no PC redirect, no interrupt re-check, and mode and banks are unchanged.
- R9: `retStrobe` in privileged mode gives `pcValid`=1 with `newPc`=`restartAddr` and `newNpc`=`restartAddr`+4, and `recheckIrq`=1, all one cycle later. Privileged mode is left only if bit 0 of `restartAddr` is 0.
- R10: A type-5 fault (arithmetic) gives `unsupFault`=1 for one cycle. There is no redirect, and the restart address and mode are unchanged.
- R11: When `faultReq` and `retStrobe` are both high, the fault is handled and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cpuId | input | IDW | Core identifier, loaded into registers 0 and 16 at reset |
| privBase | input | XLEN | Base address of the privileged handler area |
| faultReq | input | 1 | Fault or trap request |
| faultType | input | 3 | Fault kind (encodings in R4, R5, R6, R10) |
| faultVec | input | XLEN | Handler offset for vectored fault kinds |
| curPc | input | XLEN | PC of the current instruction |
| retStrobe | input | 1 | Return-from-exception request |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 5 | Register write index |
| wrData | input | XLEN | Register write data |
| rdAddr | input | 5 | Register read index |
| rdData | output | XLEN | Register read data, from the bank of the current mode |
| privMode | output | 1 | 1 while in privileged mode |
| restartAddr | output | XLEN | Exception restart address |
| newPc | output | XLEN | Redirect PC, valid while pcValid is 1 |
| newNpc | output | XLEN | PC following newPc |
| pcValid | output | 1 | One-cycle redirect pulse |
| illegalOp | output | 1 | Return attempted outside privileged mode |
| recheckIrq | output | 1 | Request to re-evaluate pending interrupts |
| unsupFault | output | 1 | Arithmetic-trap request was not taken |

## Verification
The bench goes after the corners where mode and bank can fall out of step. A write in a return cycle that went to the old bank would leave the value visible in the wrong mode. A return with the privileged marker set that still cleared the mode would expose ordinary-mode registers to the handler. An interrupt taken in privileged mode that overwrote the restart address would lose the original return point. A fault and a return in the same cycle that both acted would redirect twice or swap the banks back. Privileged calls must resume one instruction later. The two fixed vector offsets must be exact, and an arithmetic request that was taken anyway would show up as a spurious redirect.

// File: rtl/priv_shadow_pkg.sv
package priv_shadow_pkg;

  typedef enum logic [2:0] {
    FK_NONE  = 3'd0,
    FK_MCHK  = 3'd1,
    FK_ALIGN = 3'd2,
    FK_CALL  = 3'd3,
    FK_INTR  = 3'd4,
    FK_ARITH = 3'd5,
    FK_VEC6  = 3'd6,
    FK_VEC7  = 3'd7
  } faultKind_e;

  localparam logic [11:0] OFF_MCHK  = 12'h401;
  localparam logic [11:0] OFF_ALIGN = 12'h301;

  localparam int ID_REG_A = 0;
  localparam int ID_REG_B = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic swapIn;
    logic swapOut;
    logic saveRestart;
    logic restartPlus4;
    logic loadTrapPc;
    logic loadRetPc;
  } ctrlStrobes_t;

endpackage

// File: rtl/priv_shadow_ctrl.sv
module priv_shadow_ctrl
  import priv_shadow_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         faultReq,
  input  logic [2:0]   faultType,
  input  logic         retStrobe,
  input  logic         privMode,
  input  logic         restartBit0,
  output ctrlStrobes_t strobes,
  output logic         illegalOp,
  output logic         recheckIrq,
  output logic         unsupFault
);

  faultKind_e kind;
  logic       takeFault;
  logic       doReturn;
  logic       badReturn;

  always_comb begin
    kind      = faultKind_e'(faultType);
    takeFault = faultReq && (kind != FK_ARITH);
    doReturn  = retStrobe && !faultReq && privMode;
    badReturn = retStrobe && !faultReq && !privMode;

    strobes.loadTrapPc   = takeFault;
    strobes.saveRestart  = takeFault && !((kind == FK_INTR) && privMode);
    strobes.restartPlus4 = (kind == FK_CALL);
    strobes.swapIn       = takeFault && !privMode;
    strobes.loadRetPc    = doReturn;
    strobes.swapOut      = doReturn && !restartBit0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      illegalOp  <= 1'b0;
      recheckIrq <= 1'b0;
      unsupFault <= 1'b0;
    end else begin
      illegalOp  <= badReturn;
      recheckIrq <= doReturn;
      unsupFault <= faultReq && (kind == FK_ARITH);
    end
  end

  // R2: never swap both directions at once
  a_r2_single_swap: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.swapIn, strobes.swapOut}));

endmodule

// File: rtl/priv_shadow_dp.sv
module priv_shadow_dp
  import priv_shadow_pkg::*;
#(
  parameter int                XLEN        = 64,
  parameter int                IDW         = 8,
  parameter int                NREG        = 32,
  parameter logic [NREG-1:0]   SHADOW_MASK = 32'h0200_7F00
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [IDW-1:0]          cpuId,
  input  logic [XLEN-1:0]         privBase,
  input  logic [2:0]              faultType,
  input  logic [XLEN-1:0]         faultVec,
  input  logic [XLEN-1:0]         curPc,
  input  ctrlStrobes_t            strobes,
  input  logic                    wrEn,
  input  logic [$clog2(NREG)-1:0] wrAddr,
  input  logic [XLEN-1:0]         wrData,
  input  logic [$clog2(NREG)-1:0] rdAddr,
  output logic [XLEN-1:0]         rdData,
  output logic                    privMode,
  output logic [XLEN-1:0]         restartAddr,
  output logic [XLEN-1:0]         newPc,
  output logic [XLEN-1:0]         newNpc,
  output logic                    pcValid
);

  function automatic int countBits(input logic [NREG-1:0] m);
    int n = 0;
    for (int i = 0; i < NREG; i++) if (m[i]) n++;
    return n;
  endfunction

  localparam int RAW = $clog2(NREG);
  localparam int NSH = countBits(SHADOW_MASK);
  localparam int SAW = (NSH > 1) ? $clog2(NSH) : 1;

  // Slot of a shadowed register = number of shadowed registers below it
  function automatic logic [SAW-1:0] slotOf(input logic [RAW-1:0] a);
    int n = 0;
    for (int i = 0; i < NREG; i++)
      if ((i < int'(a)) && SHADOW_MASK[i]) n++;
    return SAW'(n);
  endfunction

  logic [XLEN-1:0] normalBank [NREG];
  logic [XLEN-1:0] shadowBank [NSH];
  logic            nextMode;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] trapTarget;
  logic            wrShadow;

  always_comb begin
    nextMode = strobes.swapIn ? 1'b1 : (strobes.swapOut ? 1'b0 : privMode);
    wrShadow = SHADOW_MASK[wrAddr] && nextMode;
    unique case (faultKind_e'(faultType))
      FK_NONE:  vecOffset = '0;
      FK_MCHK:  vecOffset = XLEN'(OFF_MCHK);
      FK_ALIGN: vecOffset = XLEN'(OFF_ALIGN);
      default:  vecOffset = faultVec;
    endcase
    trapTarget = privBase + vecOffset;
    rdData = (SHADOW_MASK[rdAddr] && privMode) ? shadowBank[slotOf(rdAddr)]
                                               : normalBank[rdAddr];
  end

  // Register banks; mode flag selects which copy of a shadowed register is live
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) normalBank[i] <= '0;
      for (int j = 0; j < NSH; j++)  shadowBank[j] <= '0;
      normalBank[ID_REG_A] <= XLEN'(cpuId);
      normalBank[ID_REG_B] <= XLEN'(cpuId);
      privMode <= 1'b1;
    end else begin
      privMode <= nextMode;
      if (wrEn) begin
        if (wrShadow) shadowBank[slotOf(wrAddr)] <= wrData;
        else          normalBank[wrAddr]         <= wrData;
      end
    end
  end

  // Restart address and redirect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartAddr <= '0;
      newPc       <= '0;
      newNpc      <= '0;
      pcValid     <= 1'b0;
    end else begin
      if (strobes.saveRestart)
        restartAddr <= strobes.restartPlus4 ? curPc + XLEN'(4) : curPc;
      pcValid <= strobes.loadTrapPc || strobes.loadRetPc;
      if (strobes.loadTrapPc) begin
        newPc  <= trapTarget;
        newNpc <= trapTarget + XLEN'(4);
      end else if (strobes.loadRetPc) begin
        newPc  <= restartAddr;
        newNpc <= restartAddr + XLEN'(4);
      end
    end
  end

  // R7: a swap into privileged mode is only legal from ordinary mode
  a_r7_swap_in_from_user: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swapIn |-> !privMode);

  // R9: a swap out is only legal from privileged mode
  a_r9_swap_out_from_priv: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swapOut |-> privMode);

  // R7: any taken fault ends in privileged mode
  a_r7_trap_enters_priv: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTrapPc |=> privMode);

endmodule

// File: rtl/priv_shadow_unit.sv
module priv_shadow_unit
  import priv_shadow_pkg::*;
#(
  parameter int              XLEN        = 64,
  parameter int              IDW         = 8,
  parameter int              NREG        = 32,
  parameter logic [NREG-1:0] SHADOW_MASK = 32'h0200_7F00
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [IDW-1:0]          cpuId,
  input  logic [XLEN-1:0]         privBase,
  input  logic                    faultReq,
  input  logic [2:0]              faultType,
  input  logic [XLEN-1:0]         faultVec,
  input  logic [XLEN-1:0]         curPc,
  input  logic                    retStrobe,
  input  logic                    wrEn,
  input  logic [$clog2(NREG)-1:0] wrAddr,
  input  logic [XLEN-1:0]         wrData,
  input  logic [$clog2(NREG)-1:0] rdAddr,
  output logic [XLEN-1:0]         rdData,
  output logic                    privMode,
  output logic [XLEN-1:0]         restartAddr,
  output logic [XLEN-1:0]         newPc,
  output logic [XLEN-1:0]         newNpc,
  output logic                    pcValid,
  output logic                    illegalOp,
  output logic                    recheckIrq,
  output logic                    unsupFault
);

  ctrlStrobes_t strobes;

  priv_shadow_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .faultReq    (faultReq),
    .faultType   (faultType),
    .retStrobe   (retStrobe),
    .privMode    (privMode),
    .restartBit0 (restartAddr[0]),
    .strobes     (strobes),
    .illegalOp   (illegalOp),
    .recheckIrq  (recheckIrq),
    .unsupFault  (unsupFault)
  );

  priv_shadow_dp #(
    .XLEN        (XLEN),
    .IDW         (IDW),
    .NREG        (NREG),
    .SHADOW_MASK (SHADOW_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cpuId       (cpuId),
    .privBase    (privBase),
    .faultType   (faultType),
    .faultVec    (faultVec),
    .curPc       (curPc),
    .strobes     (strobes),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .privMode    (privMode),
    .restartAddr (restartAddr),
    .newPc       (newPc),
    .newNpc      (newNpc),
    .pcValid     (pcValid)
  );

  // R8: an illegal return never redirects or re-arms interrupts
  a_r8_illegal_no_redirect: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!pcValid && !recheckIrq));

  // R6: interrupt inside privileged mode keeps the restart address
  a_r6_intr_keeps_restart: assert property (@(posedge clk) disable iff (!rstN)
    (faultReq && faultType == 3'd4 && privMode) |=> $stable(restartAddr));

  // R10: arithmetic request is not taken
  a_r10_unsup_no_redirect: assert property (@(posedge clk) disable iff (!rstN)
    unsupFault |-> !pcValid);

  // R9: the interrupt re-check comes with the return redirect
  a_r9_recheck_with_return: assert property (@(posedge clk) disable iff (!rstN)
    recheckIrq |-> pcValid);

  // R11: a fault masks a simultaneous return
  a_r11_fault_beats_return: assert property (@(posedge clk) disable iff (!rstN)
    (faultReq && retStrobe) |=> (!recheckIrq && !illegalOp));

endmodule

// File: tb/priv_shadow_unit_tb.sv
`timescale 1ns/1ps
module priv_shadow_unit_tb;
  localparam int XLEN = 64;
  localparam int IDW  = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [IDW-1:0]  cpuId = 8'h5A;
  logic [XLEN-1:0] privBase = '0, faultVec = '0, curPc = '0, wrData = '0;
  logic            faultReq = 0, retStrobe = 0, wrEn = 0;
  logic [2:0]      faultType = '0;
  logic [4:0]      wrAddr = '0, rdAddr = '0;
  logic [XLEN-1:0] rdData, restartAddr, newPc, newNpc;
  logic            privMode, pcValid, illegalOp, recheckIrq, unsupFault;

  always #2.5 clk = ~clk;

  priv_shadow_unit u_dut (
    .clk(clk), .rstN(rstN), .cpuId(cpuId), .privBase(privBase),
    .faultReq(faultReq), .faultType(faultType), .faultVec(faultVec),
    .curPc(curPc), .retStrobe(retStrobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .privMode(privMode),
    .restartAddr(restartAddr), .newPc(newPc), .newNpc(newNpc),
    .pcValid(pcValid), .illegalOp(illegalOp), .recheckIrq(recheckIrq),
    .unsupFault(unsupFault)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Bench model
  logic [XLEN-1:0] eNorm [32];
  logic [XLEN-1:0] eShad [32];
  logic            eMode;
  logic [XLEN-1:0] eRestart;

  function automatic bit isSh(int a);
    return (a >= 8 && a <= 14) || a == 25;
  endfunction

  function automatic logic [XLEN-1:0] expRead(int a);
    return (isSh(a) && eMode) ? eShad[a] : eNorm[a];
  endfunction

  function automatic logic [XLEN-1:0] expOffset(logic [2:0] t, logic [XLEN-1:0] v);
    case (t)
      3'd0:    return '0;
      3'd1:    return 64'h401;
      3'd2:    return 64'h301;
      default: return v;
    endcase
  endfunction

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readChk(string tag, int a);
    rdAddr = 5'(a);
    #1;
    chk(tag, rdData, expRead(a));
  endtask

  // One cycle of stimulus, called at a falling edge
  task automatic step(bit fReq, logic [2:0] fType, logic [XLEN-1:0] fVec,
                      logic [XLEN-1:0] pc, logic [XLEN-1:0] base, bit ret,
                      bit wr, logic [4:0] wa, logic [XLEN-1:0] wd);
    bit take, doRet, bad, arith, expValid;
    logic [XLEN-1:0] expPc;
    string pcTag;
    faultReq = fReq; faultType = fType; faultVec = fVec; curPc = pc;
    privBase = base; retStrobe = ret; wrEn = wr; wrAddr = wa; wrData = wd;

    arith = fReq && fType == 3'd5;
    take  = fReq && !arith;
    doRet = ret && !fReq && eMode;
    bad   = ret && !fReq && !eMode;
    expValid = take || doRet;
    expPc = take ? base + expOffset(fType, fVec) : eRestart;
    pcTag = (fReq && ret) ? "R11" : (take ? "R4" : (doRet ? "R9" : (bad ? "R8" : "R10")));
    if (take && !(fType == 3'd4 && eMode))
      eRestart = pc + ((fType == 3'd3) ? 64'd4 : 64'd0);
    if (take) eMode = 1'b1;
    else if (doRet && !expPc[0]) eMode = 1'b0;
    if (wr) begin
      if (isSh(int'(wa)) && eMode) eShad[wa] = wd;
      else                         eNorm[wa] = wd;
    end

    @(posedge clk);
    @(negedge clk);
    chk(pcTag, 64'(pcValid), 64'(expValid));
    if (expValid) begin
      chk(pcTag, newPc, expPc);
      chk(pcTag, newNpc, expPc + 64'd4);
    end
    chk((take && fType == 3'd4) ? "R6" : "R5", restartAddr, eRestart);
    chk(doRet ? "R9" : "R7", 64'(privMode), 64'(eMode));
    chk("R8", 64'(illegalOp), 64'(bad));
    chk("R9", 64'(recheckIrq), 64'(doRet));
    chk("R10", 64'(unsupFault), 64'(arith));
    faultReq = 0; retStrobe = 0; wrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin eNorm[i] = '0; eShad[i] = '0; end
    eNorm[0]  = 64'(cpuId);
    eNorm[16] = 64'(cpuId);
    eMode = 1'b1;
    eRestart = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", 64'(privMode), 64'd1);
    chk("R1", 64'(pcValid), 64'd0);
    chk("R1", restartAddr, 64'd0);
    chk("R1", 64'({illegalOp, recheckIrq, unsupFault}), 64'd0);
    for (int a = 0; a < 32; a++) readChk("R1", a);

    // R2: write shadow r9 in privileged mode, return (bit0 = 0) leaves mode
    step(0, 0, 0, 0, 64'h1000, 0, 1, 5'd9, 64'hAAAA_0009);
    step(0, 0, 0, 0, 64'h1000, 1, 0, 0, 0);
    readChk("R2", 9);
    step(0, 0, 0, 0, 64'h1000, 0, 1, 5'd9, 64'hBBBB_0009);
    step(0, 0, 0, 0, 64'h1000, 0, 1, 5'd1, 64'h1111);
    readChk("R2", 9);
    // R4 + R5 + R7: machine check from user mode
    step(1, 3'd1, 0, 64'h4000, 64'h8000, 0, 0, 0, 0);
    readChk("R2", 9);
    readChk("R2", 1);
    // R6: interrupt while privileged keeps restart
    step(1, 3'd4, 64'h500, 64'h7770, 64'h8000, 0, 0, 0, 0);
    // R3: write in the return cycle goes to the ordinary bank
    step(0, 0, 0, 0, 64'h8000, 1, 1, 5'd10, 64'hCAFE);
    readChk("R3", 10);
    step(1, 3'd2, 0, 64'h4100, 64'h8000, 0, 0, 0, 0);
    readChk("R3", 10);
    // R5: privileged call from... privileged: restart = pc+4, odd pc keeps mode on return
    step(1, 3'd3, 64'h80, 64'h5001, 64'h8000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 64'h8000, 1, 0, 0, 0);
    chk("R9", 64'(privMode), 64'd1);
    // R10: arithmetic request
    step(1, 3'd5, 64'h44, 64'h6000, 64'h8000, 0, 0, 0, 0);
    // R11: fault and return together
    step(1, 3'd0, 0, 64'h6100, 64'h9000, 1, 0, 0, 0);
    // R8: return in ordinary mode
    step(1, 3'd6, 64'h10, 64'h2000, 64'h9000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 64'h9000, 1, 0, 0, 0);
    step(0, 0, 0, 0, 64'h9000, 1, 0, 0, 0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom % 8;
      bit fr = (op == 3 || op == 5 || op == 6);
      bit rt = (op == 4 || op == 5 || op == 7);
      step(fr, 3'($urandom % 8), {32'd0, $urandom},
           {$urandom, $urandom}, {$urandom, 32'd0}, rt,
           1'($urandom % 2), 5'($urandom % 32), {$urandom, $urandom});
      readChk("R2", int'($urandom % 32));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule